// File: doc/BRIEF.md
# Streaming CRC-16 Trailer Appender

This block sits in a byte-wide AXI4-Stream transmit path. Payload bytes pass straight through, and a 16-bit CRC is computed over them as they go. When the beat that upstream marks with TLAST has been forwarded, the block adds two beats of its own that carry the CRC. The end-of-packet marker moves from the last payload byte to the final CRC byte, so every packet leaves two beats longer than it arrived.

Backpressure works in both directions. The CRC advances only on beats that are actually accepted. While the trailer is being emitted, the upstream side is held off. The polynomial, the initial value and the order of the two CRC bytes are parameters. After the trailer's last beat is handed off, the accumulator returns to its initial value for the next packet. An asynchronous active-low reset is released synchronously inside the block.

Top module: `crc16_trailer_stream`

## Requirements
- R1: While no trailer is pending, each output beat equals the input beat: m_tvalid follows s_tvalid and m_tdata follows s_tdata, and m_tlast stays 0 on every payload beat.
- R2: After the input beat with s_tlast=1 is accepted, exactly two trailer beats follow. With HI_FIRST=1 the first carries CRC bits [15:8] and the second carries bits [7:0]. Only the second beat has m_tlast=1.
- R3: The CRC is computed MSB-first with no reflection and no final XOR, using polynomial POLY (default 0x1021) and start value INIT (default 0xFFFF). For the nine ASCII bytes "123456789" the result is 0x29B1.
- R4: s_tready is 0 from the cycle after the last payload byte is accepted until the final trailer beat has been handed off.
- R5: The CRC absorbs only beats on which s_tvalid and s_tready are both 1. While m_tready is 0, a trailer beat keeps its data and stays valid, and the CRC value is unchanged by any pattern of stalls or gaps.
- R6: Each packet's CRC starts again from INIT, so two packets with the same payload carry the same trailer.
- R7: A packet of one payload byte produces exactly three output beats.
- R8: An asserted reset, including one that arrives mid-trailer, returns the block to pass-through with the CRC at INIT. Directly after reset, with s_tvalid=0 and m_tready=1, the outputs are m_tvalid=0 and s_tready=1.
- R9: During payload, s_tready equals m_tready, so no input beat is accepted while the output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | 8 | Input payload byte |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Block accepts an input beat |
| s_tlast | input | 1 | Input beat is the last payload byte |
| m_tdata | output | 8 | Output byte (payload or CRC) |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts an output beat |
| m_tlast | output | 1 | Output beat ends the packet (low CRC byte) |

## Verification
The bench drives one-byte packets, which would expose a design that drops a trailer beat or puts TLAST on the high CRC byte. It pairs stall patterns on m_tready with gaps on s_tvalid over the same payload. A design that advanced the CRC on offered but unaccepted beats would then produce different trailers for identical data. Repeated packets catch an accumulator that is not cleared, and the standard check string pins down the polynomial, the bit order and the byte order. A reset in the middle of a trailer, followed by a clean packet, shows whether the sequencer or the CRC carries stale state.

// File: rtl/crc_trl_pkg.sv
package crc_trl_pkg;

  parameter int CRC_W  = 16;
  parameter int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_PAYLOAD = 2'd0,
    PH_TRL_A   = 2'd1,
    PH_TRL_B   = 2'd2
  } phase_t;

  // One byte folded into the CRC, most significant data bit first.
  function automatic logic [CRC_W-1:0] crc_fold_byte(
    input logic [CRC_W-1:0]  crc_in,
    input logic [BYTE_W-1:0] data_in,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = crc_in;
    for (int k = BYTE_W - 1; k >= 0; k--) begin
      fb  = acc[CRC_W-1] ^ data_in[k];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ poly;
    end
    return acc;
  endfunction

endpackage

// File: rtl/crc_trl_rst_sync.sv
module crc_trl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/crc_trl_accum.sv
module crc_trl_accum
  import crc_trl_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [BYTE_W-1:0] upd_byte,
  input  logic              clr_en,
  output logic [CRC_W-1:0]  crc_q
);
  logic [CRC_W-1:0] crc_d;
  logic             crc_en;

  assign crc_en = upd_en | clr_en;

  always_comb begin
    crc_d = crc_q;
    if (clr_en)      crc_d = INIT;
    else if (upd_en) crc_d = crc_fold_byte(crc_q, upd_byte, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= INIT;
    else if (crc_en) crc_q <= crc_d;
  end
endmodule

// File: rtl/crc_trl_seq.sv
module crc_trl_seq
  import crc_trl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   s_tvalid,
  input  logic   s_tlast,
  input  logic   m_tready,
  output logic   s_tready,
  output logic   m_tvalid,
  output logic   m_tlast,
  output logic   accept,
  output logic   trl_clear,
  output phase_t phase
);
  phase_t phase_d;
  logic   phase_en;

  always_comb begin
    phase_d   = phase;
    s_tready  = 1'b0;
    m_tvalid  = 1'b0;
    m_tlast   = 1'b0;
    accept    = 1'b0;
    trl_clear = 1'b0;
    unique case (phase)
      PH_PAYLOAD: begin
        s_tready = m_tready;
        m_tvalid = s_tvalid;
        accept   = s_tvalid & m_tready;
        if (accept && s_tlast) phase_d = PH_TRL_A;
      end
      PH_TRL_A: begin
        m_tvalid = 1'b1;
        if (m_tready) phase_d = PH_TRL_B;
      end
      PH_TRL_B: begin
        m_tvalid = 1'b1;
        m_tlast  = 1'b1;
        if (m_tready) begin
          phase_d   = PH_PAYLOAD;
          trl_clear = 1'b1;
        end
      end
      default: phase_d = PH_PAYLOAD;
    endcase
  end

  assign phase_en = (phase_d != phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase <= PH_PAYLOAD;
    else if (phase_en) phase <= phase_d;
  end
endmodule

// File: rtl/crc_trl_outmux.sv
module crc_trl_outmux
  import crc_trl_pkg::*;
#(
  parameter bit HI_FIRST = 1'b1
) (
  input  phase_t            phase,
  input  logic [BYTE_W-1:0] pay_byte,
  input  logic [CRC_W-1:0]  crc,
  output logic [BYTE_W-1:0] out_byte
);
  localparam int NB = CRC_W / BYTE_W;
  logic [BYTE_W-1:0] first_b;
  logic [BYTE_W-1:0] second_b;

  generate
    if (HI_FIRST) begin : g_hi_first
      assign first_b  = crc[CRC_W-1 -: BYTE_W];
      assign second_b = crc[BYTE_W-1:0];
    end else begin : g_lo_first
      assign first_b  = crc[BYTE_W-1:0];
      assign second_b = crc[CRC_W-1 -: BYTE_W];
    end
  endgenerate

  always_comb begin
    unique case (phase)
      PH_TRL_A: out_byte = first_b;
      PH_TRL_B: out_byte = second_b;
      default:  out_byte = pay_byte;
    endcase
  end

  initial begin
    if (NB != 2) $error("crc_trl_outmux: CRC must span two bytes");
  end
endmodule

// File: rtl/crc16_trailer_stream.sv
module crc16_trailer_stream
  import crc_trl_pkg::*;
#(
  parameter logic [15:0] POLY     = 16'h1021,
  parameter logic [15:0] INIT     = 16'hFFFF,
  parameter bit          HI_FIRST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] s_tdata,
  input  logic       s_tvalid,
  output logic       s_tready,
  input  logic       s_tlast,
  output logic [7:0] m_tdata,
  output logic       m_tvalid,
  input  logic       m_tready,
  output logic       m_tlast
);
  logic             rst_sync_n;
  logic             accept;
  logic             trl_clear;
  logic [CRC_W-1:0] crc_q;
  phase_t           phase;

  crc_trl_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  crc_trl_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .s_tvalid  (s_tvalid),
    .s_tlast   (s_tlast),
    .m_tready  (m_tready),
    .s_tready  (s_tready),
    .m_tvalid  (m_tvalid),
    .m_tlast   (m_tlast),
    .accept    (accept),
    .trl_clear (trl_clear),
    .phase     (phase)
  );

  crc_trl_accum #(.POLY(POLY), .INIT(INIT)) u_crc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .upd_en   (accept),
    .upd_byte (s_tdata),
    .clr_en   (trl_clear),
    .crc_q    (crc_q)
  );

  crc_trl_outmux #(.HI_FIRST(HI_FIRST)) u_mux (
    .phase    (phase),
    .pay_byte (s_tdata),
    .crc      (crc_q),
    .out_byte (m_tdata)
  );
endmodule

// File: rtl/crc_trl_checker.sv
module crc_trl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] s_tdata,
  input logic       s_tvalid,
  input logic       s_tready,
  input logic       s_tlast,
  input logic [7:0] m_tdata,
  input logic       m_tvalid,
  input logic       m_tready,
  input logic       m_tlast
);
  // Independent tracker of the trailer position, built from port handshakes only.
  logic [1:0] trk_q;
  logic [1:0] trk_d;

  always_comb begin
    trk_d = trk_q;
    case (trk_q)
      2'd0:    if (s_tvalid && s_tready && s_tlast) trk_d = 2'd1;
      2'd1:    if (m_tvalid && m_tready) trk_d = 2'd2;
      2'd2:    if (m_tvalid && m_tready) trk_d = 2'd0;
      default: trk_d = 2'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trk_q <= 2'd0;
    else        trk_q <= trk_d;
  end

  AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_q == 2'd0) |-> (m_tvalid == s_tvalid && m_tdata == s_tdata && !m_tlast)); // R1
  AST_TRAILER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_q != 2'd0) |-> m_tvalid); // R2
  AST_LAST_ON_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tlast) |-> (trk_q == 2'd2)); // R2
  AST_NO_INPUT_IN_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_q != 2'd0) |-> !s_tready); // R4
  AST_TRAILER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_q != 2'd0 && m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R5
  AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_q == 2'd0) |-> (s_tready == m_tready)); // R9
endmodule

bind crc16_trailer_stream crc_trl_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .s_tdata  (s_tdata),
  .s_tvalid (s_tvalid),
  .s_tready (s_tready),
  .s_tlast  (s_tlast),
  .m_tdata  (m_tdata),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tlast  (m_tlast)
);

// File: tb/test_crc16_trailer_stream.sv
module test_crc16_trailer_stream;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {len, first byte, byte step, m_tready pattern, s_tvalid pattern}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd1,  8'h00, 8'h00, 8'hFF, 8'hFF},
    {8'd9,  8'h31, 8'h01, 8'hFF, 8'hFF},
    {8'd16, 8'hA5, 8'h3B, 8'h5A, 8'hFF},
    {8'd16, 8'hA5, 8'h3B, 8'hFF, 8'h93},
    {8'd16, 8'hA5, 8'h3B, 8'h36, 8'hC5},
    {8'd1,  8'hFF, 8'h00, 8'h0F, 8'h55},
    {8'd40, 8'h07, 8'h11, 8'h6D, 8'hB7},
    {8'd2,  8'h80, 8'h01, 8'h01, 8'hFF}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] s_tdata = 8'h00;
  logic       s_tvalid = 1'b0;
  logic       s_tlast = 1'b0;
  logic       m_tready = 1'b0;
  logic       s_tready, m_tvalid, m_tlast;
  logic [7:0] m_tdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0]  pay [0:63];
  logic [7:0]  od  [0:79];
  logic        ol  [0:79];
  int          n_out;
  logic [15:0] last_trailer;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_trailer_stream i_crc16_trailer_stream (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Reference CRC: byte XORed into the top of the register, then eight shifts.
  function automatic logic [15:0] ref_crc(input int len);
    logic [15:0] c = 16'hFFFF;
    for (int b = 0; b < len; b++) begin
      c = c ^ {pay[b], 8'h00};
      for (int s = 0; s < 8; s++)
        c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic run_pkt(input int len, input logic [7:0] base, input logic [7:0] step,
                         input logic [7:0] omask, input logic [7:0] imask, input string tag);
    int i = 0;
    int cyc = 0;
    bit pend = 1'b0;
    bit done = 1'b0;
    bit err_rdy = 1'b0;
    bit err_stall = 1'b0;
    bit acc;
    bit pay_ok = 1'b1;
    logic [15:0] exp_crc;
    for (int k = 0; k < len; k++) pay[k] = base + 8'(k) * step;
    n_out = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      m_tready = omask[cyc % 8];
      if (!pend && i < len && imask[cyc % 8]) pend = 1'b1;
      s_tvalid = pend;
      s_tdata  = pend ? pay[i] : 8'h00;
      s_tlast  = pend && (i == len - 1);
      #1;
      if (i == len && s_tready) err_rdy = 1'b1;
      if (i < len && s_tready != m_tready) err_stall = 1'b1;
      acc = s_tvalid && s_tready;
      if (m_tvalid && m_tready) begin
        od[n_out] = m_tdata;
        ol[n_out] = m_tlast;
        n_out++;
        if (m_tlast) done = 1'b1;
      end
      @(posedge clk);
      if (acc) begin pend = 1'b0; i++; end
      cyc++;
    end
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0; m_tready = 1'b1;
    exp_crc = ref_crc(len);
    last_trailer = (n_out >= 2) ? {od[n_out-2], od[n_out-1]} : 16'h0000;
    check(n_out == len + 2, {"R7 beat count ", tag}, n_out, len + 2);
    for (int k = 0; k < len && k < n_out; k++)
      if (od[k] !== pay[k] || ol[k] !== 1'b0) pay_ok = 1'b0;
    check(pay_ok, {"R1 payload ", tag}, 0, 1);
    check(last_trailer == exp_crc, {"R2 R3 R5 R6 trailer ", tag}, last_trailer, exp_crc);
    check(n_out >= 2 && ol[n_out-1] == 1'b1 && ol[n_out-2] == 1'b0,
          {"R2 tlast on final byte ", tag}, n_out, len + 2);
    check(!err_rdy, {"R4 s_tready low in trailer ", tag}, err_rdy, 0);
    check(!err_stall, {"R9 s_tready follows m_tready ", tag}, err_stall, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_tready = 1'b1; s_tvalid = 1'b0;
    #1;
    // R8: idle state after reset
    check(m_tvalid == 1'b0, "R8 reset m_tvalid", m_tvalid, 0);
    check(s_tready == 1'b1, "R8 reset s_tready", s_tready, 1);

    for (int v = 0; v < NVEC; v++)
      run_pkt(int'(VEC[v][39:32]), VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0],
              $sformatf("vec%0d", v));

    // R3: standard check string
    run_pkt(9, 8'h31, 8'h01, 8'hFF, 8'hFF, "check string");
    check(last_trailer == 16'h29B1, "R3 check string literal", last_trailer, 16'h29B1);

    // R8: reset in the middle of a trailer
    @(negedge clk);
    m_tready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      s_tvalid = 1'b1; s_tdata = 8'h5C + 8'(k); s_tlast = (k == 2);
      @(negedge clk);
    end
    s_tvalid = 1'b0; s_tlast = 1'b0; m_tready = 1'b0;
    #1;
    check(m_tvalid == 1'b1 && s_tready == 1'b0, "R4 trailer pending before reset", m_tvalid, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_tready = 1'b1;
    #1;
    check(m_tvalid == 1'b0 && m_tlast == 1'b0, "R8 mid-trailer reset clears trailer", m_tvalid, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_pkt(9, 8'h31, 8'h01, 8'hFF, 8'hFF, "after reset");
    check(last_trailer == 16'h29B1, "R8 R6 crc fresh after reset", last_trailer, 16'h29B1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule